// File: doc/BRIEF.md
# Dual-Rail Receive Output Formatter

This block sits at the output of a line receiver. It shapes recovered dual-rail marks, positive and negative, before they leave the receiver. The block runs on a clock at `DIV` times the line bit rate, and an internal phase counter divides each bit period into `DIV` cycles. On the last cycle of every period, the block captures the raw mark strobes, the 3-bit mode select and the mute, invert and clock-invert controls. It then plays that captured state out for the whole of the next period. Because of this, a control change never cuts a pulse short.

The mode code decides how wide the output marks are. Return-to-zero codes give marks that last half the period. Full-width codes give marks that last the whole period. The reserved code silences both rails and raises an error flag. Muting blanks both rails, and the mute input may be tied straight to a loss-of-signal flag. Inversion is applied last, so a blanked rail rests at the inverted idle level. The generated output clock is high in the first half of the period and low in the second half. When clock-invert is set, the output clock is inverted so that data changes on its falling edge. A decoded mode bus tells downstream blocks which line format is active.

Top module: `rxfmt_out`

## Requirements
- R1: One bit period lasts exactly `DIV` clock cycles. With clock-invert clear, `tx_clk` is 1 in the first `DIV/2` cycles and 0 in the rest, so each period starts on a rising edge.
- R2: With clock-invert set, `tx_clk` is 0 in the first half and 1 in the second half, so data changes on a falling edge of `tx_clk`.
- R3: `mode_flags` decodes the captured code as follows: bit 0 is full width, bit 1 is the 64 kHz family, bit 2 is 400 Hz present, bit 3 is E1, bit 4 is T1 and bit 5 is reserved. The code-to-flags map is 000→000010, 001→000110, 010→001000, 011→001001, 100→010000, 101→010001, 110→001001 and 111→100000.
- R4: Under the return-to-zero codes (000, 001, 010, 100), a captured mark drives its rail active only in the first `DIV/2` cycles of the period.
- R5: Under the full-width codes (011, 101, 110), a captured mark drives its rail active for all `DIV` cycles of the period.
- R6: When mute is captured, both rails are inactive for the whole period, whatever the marks are. With invert clear, inactive means 0.
- R7: When invert is captured, the rails are active low. Inversion is applied after muting and reserved-code blanking, so a blanked rail with invert set reads 1.
- R8: The reserved code 111 holds both rails at their inactive level and sets `mode_flags` bit 5.
- R9: Inputs are sampled only on the last cycle of a period. Changes made at any other cycle have no effect on the outputs until the following period.
- R10: While reset is held, `tx_pos` and `tx_neg` are 0, `tx_clk` is 1 and `mode_flags` is 000010.
- R11: Each rail follows only its own strobe: `rx_pos` drives only `tx_pos`, and `rx_neg` drives only `tx_neg`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at DIV times the bit rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_pos | input | 1 | Raw positive-rail mark strobe |
| rx_neg | input | 1 | Raw negative-rail mark strobe |
| mode_sel | input | 3 | Line mode select code |
| mute | input | 1 | Blank both rails |
| invert | input | 1 | Make rails active low |
| clk_inv | input | 1 | Launch data on falling edge of tx_clk |
| tx_pos | output | 1 | Formatted positive rail |
| tx_neg | output | 1 | Formatted negative rail |
| tx_clk | output | 1 | Output bit clock |
| mode_flags | output | 6 | Decoded mode bus |

## Verification
The bench builds the block with `DIV` = 6. This makes the half period 3 cycles, which is odd, and makes the phase counter wrap at a value that is not a power of two. It also keeps each period short enough that every mode code can be combined with every control pin in one table walk. Each period is checked cycle by cycle against an independent model of pulse width and clock phase. A directed test changes every input in the middle of a period, which shows that sampling at the period boundary blocks partial pulses.

// File: rtl/rxfmt_pkg.sv
package rxfmt_pkg;

  typedef struct packed {
    logic [2:0] code;
    logic       pos;
    logic       neg;
    logic       mute;
    logic       inv;
    logic       cinv;
  } cfg_t;

  // bit order matters: downstream blocks decode by position
  typedef struct packed {
    logic rsvd;
    logic is_t1;
    logic is_e1;
    logic has_400;
    logic is_64k;
    logic full;
  } mode_flags_t;

  function automatic mode_flags_t decode_mode(input logic [2:0] code);
    mode_flags_t f;
    f = '0;
    unique case (code)
      3'b000: f.is_64k = 1'b1;
      3'b001: begin f.is_64k = 1'b1; f.has_400 = 1'b1; end
      3'b010: f.is_e1 = 1'b1;
      3'b011: begin f.is_e1 = 1'b1; f.full = 1'b1; end
      3'b100: f.is_t1 = 1'b1;
      3'b101: begin f.is_t1 = 1'b1; f.full = 1'b1; end
      3'b110: begin f.is_e1 = 1'b1; f.full = 1'b1; end
      default: f.rsvd = 1'b1;
    endcase
    return f;
  endfunction

  // width gate, then blanking, then polarity: order is part of the behaviour
  function automatic logic rail_level(input logic mark, input logic full,
                                      input logic first_half, input logic blank,
                                      input logic inv);
    logic active;
    active = mark & (full | first_half) & ~blank;
    return active ^ inv;
  endfunction

endpackage

// File: rtl/rxfmt_phase.sv
module rxfmt_phase #(
  parameter int DIV = 32
) (
  input  logic clk,
  input  logic rst_n,
  output logic bnd,
  output logic first_half
);
  localparam int CW   = (DIV > 2) ? $clog2(DIV) : 1;
  localparam int HALF = DIV / 2;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);
  localparam logic [CW-1:0] MID  = CW'(HALF);

  logic [CW-1:0] ph;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          ph <= '0;
    else if (ph == LAST) ph <= '0;
    else                 ph <= ph + 1'b1;
  end

  assign bnd        = (ph == LAST);
  assign first_half = (ph < MID);
endmodule

// File: rtl/rxfmt_capture.sv
module rxfmt_capture
  import rxfmt_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic bnd,
  input  cfg_t cfg_d,
  output cfg_t cfg_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cfg_q <= '0;
    else if (bnd) cfg_q <= cfg_d;
  end
endmodule

// File: rtl/rxfmt_rail.sv
module rxfmt_rail
  import rxfmt_pkg::*;
(
  input  logic mark,
  input  logic full,
  input  logic first_half,
  input  logic blank,
  input  logic inv,
  output logic level
);
  always_comb level = rail_level(mark, full, first_half, blank, inv);
endmodule

// File: rtl/rxfmt_out.sv
module rxfmt_out
  import rxfmt_pkg::*;
#(
  parameter int DIV = 32
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_pos,
  input  logic       rx_neg,
  input  logic [2:0] mode_sel,
  input  logic       mute,
  input  logic       invert,
  input  logic       clk_inv,
  output logic       tx_pos,
  output logic       tx_neg,
  output logic       tx_clk,
  output logic [5:0] mode_flags
);
  localparam int NRAIL = 2;

  logic        bnd_w;
  logic        first_half_w;
  cfg_t        cfg_d, cfg_q;
  mode_flags_t flags_w;
  logic        blank_w;
  logic        cfg_mute_w, cfg_inv_w, cfg_cinv_w;
  logic [NRAIL-1:0] mark_w, level_w;

  rxfmt_phase #(.DIV(DIV)) u_phase (
    .clk(clk), .rst_n(rst_n), .bnd(bnd_w), .first_half(first_half_w)
  );

  always_comb begin
    cfg_d.code = mode_sel;
    cfg_d.pos  = rx_pos;
    cfg_d.neg  = rx_neg;
    cfg_d.mute = mute;
    cfg_d.inv  = invert;
    cfg_d.cinv = clk_inv;
  end

  rxfmt_capture u_capture (
    .clk(clk), .rst_n(rst_n), .bnd(bnd_w), .cfg_d(cfg_d), .cfg_q(cfg_q)
  );

  assign flags_w    = decode_mode(cfg_q.code);
  assign cfg_mute_w = cfg_q.mute;
  assign cfg_inv_w  = cfg_q.inv;
  assign cfg_cinv_w = cfg_q.cinv;
  assign blank_w    = cfg_q.mute | flags_w.rsvd;
  assign mark_w     = {cfg_q.neg, cfg_q.pos};

  for (genvar r = 0; r < NRAIL; r++) begin : g_rail
    rxfmt_rail u_rail (
      .mark(mark_w[r]), .full(flags_w.full), .first_half(first_half_w),
      .blank(blank_w), .inv(cfg_q.inv), .level(level_w[r])
    );
  end

  assign tx_pos     = level_w[0];
  assign tx_neg     = level_w[1];
  assign tx_clk     = first_half_w ^ cfg_q.cinv;
  assign mode_flags = flags_w;
endmodule

// File: rtl/rxfmt_out_chk.sv
module rxfmt_out_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       bnd,
  input logic       first_half,
  input logic       cfg_mute,
  input logic       cfg_inv,
  input logic       cfg_cinv,
  input logic       tx_pos,
  input logic       tx_neg,
  input logic       tx_clk,
  input logic [5:0] mode_flags
);
  AST_PERIOD_START_CLK: assert property (@(posedge clk) disable iff (!rst_n)
    bnd |=> (tx_clk == !cfg_cinv)); // R1

  AST_SECOND_HALF_CLK: assert property (@(posedge clk) disable iff (!rst_n)
    !first_half |-> (tx_clk == cfg_cinv)); // R2

  AST_FLAGS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(bnd) |-> $stable(mode_flags)); // R9

  AST_FLAGS_ONEHOT_FMT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mode_flags[5], mode_flags[4], mode_flags[3], mode_flags[1]})); // R3

  AST_RZ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_flags[0] && !first_half) |-> (tx_pos == cfg_inv && tx_neg == cfg_inv)); // R4

  AST_FULL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_flags[0] && !$past(bnd)) |-> ($stable(tx_pos) && $stable(tx_neg))); // R5

  AST_MUTE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_mute |-> (tx_pos == cfg_inv && tx_neg == cfg_inv)); // R6

  AST_RSVD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    mode_flags[5] |-> (tx_pos == cfg_inv && tx_neg == cfg_inv)); // R8
endmodule

bind rxfmt_out rxfmt_out_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bnd(bnd_w), .first_half(first_half_w),
  .cfg_mute(cfg_mute_w), .cfg_inv(cfg_inv_w), .cfg_cinv(cfg_cinv_w),
  .tx_pos(tx_pos), .tx_neg(tx_neg), .tx_clk(tx_clk), .mode_flags(mode_flags)
);

// File: tb/test_rxfmt_out.sv
module test_rxfmt_out;
  localparam int DIV  = 6;
  localparam int HALF = DIV / 2;
  localparam int NVEC = 18;

  // vector: [7:5] code, [4] pos, [3] neg, [2] mute, [1] invert, [0] clk_inv
  localparam logic [7:0] VEC [NVEC] = '{
    8'b000_10_000, 8'b000_01_000, 8'b001_11_000, 8'b010_10_001,
    8'b011_10_000, 8'b011_01_010, 8'b100_11_000, 8'b101_10_000,
    8'b110_01_001, 8'b111_11_000, 8'b111_11_010, 8'b010_11_100,
    8'b110_11_110, 8'b101_00_010, 8'b100_01_011, 8'b001_10_000,
    8'b000_00_000, 8'b011_11_001
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_pos = 1'b0, rx_neg = 1'b0, mute = 1'b0, invert = 1'b0, clk_inv = 1'b0;
  logic [2:0] mode_sel = 3'b000;
  logic tx_pos, tx_neg, tx_clk;
  logic [5:0] mode_flags;

  int applied = 0;
  int miscmp  = 0;
  int bph = 0;

  always #5 clk = ~clk;

  rxfmt_out #(.DIV(DIV)) i_rxfmt_out (
    .clk(clk), .rst_n(rst_n), .rx_pos(rx_pos), .rx_neg(rx_neg),
    .mode_sel(mode_sel), .mute(mute), .invert(invert), .clk_inv(clk_inv),
    .tx_pos(tx_pos), .tx_neg(tx_neg), .tx_clk(tx_clk), .mode_flags(mode_flags)
  );

  // period position as the requirements define it (R1)
  always @(posedge clk) begin
    if (!rst_n) bph <= 0;
    else        bph <= (bph == DIV - 1) ? 0 : bph + 1;
  end

  function automatic logic [5:0] exp_flags(input logic [2:0] c);
    case (c)
      3'b000: return 6'b000010;
      3'b001: return 6'b000110;
      3'b010: return 6'b001000;
      3'b011: return 6'b001001;
      3'b100: return 6'b010000;
      3'b101: return 6'b010001;
      3'b110: return 6'b001001;
      default: return 6'b100000;
    endcase
  endfunction

  // expected {tx_pos, tx_neg, tx_clk} at position p of a period run with v
  function automatic logic [2:0] exp_out(input logic [7:0] v, input int p);
    logic wide, rsvd, quiet, show, ep, en, ec;
    wide  = (v[7:5] == 3'b011) || (v[7:5] == 3'b101) || (v[7:5] == 3'b110);
    rsvd  = (v[7:5] == 3'b111);
    quiet = v[2] || rsvd;
    show  = wide || (p < HALF);
    ep = (v[4] && show && !quiet) ? 1'b1 : 1'b0;
    en = (v[3] && show && !quiet) ? 1'b1 : 1'b0;
    if (v[1]) begin ep = !ep; en = !en; end
    ec = (p < HALF) ? !v[0] : v[0];
    return {ep, en, ec};
  endfunction

  task automatic drive(input logic [7:0] v);
    mode_sel = v[7:5]; rx_pos = v[4]; rx_neg = v[3];
    mute = v[2]; invert = v[1]; clk_inv = v[0];
  endtask

  // compares one sample; reports only the first mismatch of a vector
  task automatic sample(input logic [7:0] v, input int p, input string req, inout bit ok);
    logic [2:0] e;
    e = exp_out(v, p);
    if (ok && ({tx_pos, tx_neg, tx_clk} !== e || mode_flags !== exp_flags(v[7:5]))) begin
      $display("FAIL %s vec=%b phase=%0d actual pos/neg/clk=%b flags=%b expected %b flags=%b",
               req, v, p, {tx_pos, tx_neg, tx_clk}, mode_flags, e, exp_flags(v[7:5]));
      ok = 1'b0;
    end
  endtask

  task automatic finish_vec(input bit ok);
    applied++;
    if (!ok) miscmp++;
  endtask

  bit done = 1'b0;

  initial begin
    bit ok;
    // R10: reset state
    repeat (3) @(negedge clk);
    applied++;
    if ({tx_pos, tx_neg, tx_clk} !== 3'b001 || mode_flags !== 6'b000010) begin
      miscmp++;
      $display("FAIL R10 actual pos/neg/clk=%b flags=%b expected 001 flags=000010",
               {tx_pos, tx_neg, tx_clk}, mode_flags);
    end
    rst_n = 1'b1;
    do @(negedge clk); while (bph != DIV - 1);

    // table walk: R1 R2 R3 R4 R5 R6 R7 R8 R11
    for (int i = 0; i < NVEC; i++) begin
      drive(VEC[i]);
      ok = 1'b1;
      for (int p = 0; p < DIV; p++) begin
        @(negedge clk);
        sample(VEC[i], p, "R1/R2/R3/R4/R5/R6/R7/R8/R11", ok);
      end
      finish_vec(ok);
    end

    // R9: inputs changed mid-period leave the current period untouched
    drive(8'b011_10_000);
    ok = 1'b1;
    for (int p = 0; p < DIV; p++) begin
      @(negedge clk);
      sample(8'b011_10_000, p, "R9", ok);
      if (p == 1) drive(8'b111_01_111);
    end
    finish_vec(ok);
    ok = 1'b1;
    for (int p = 0; p < DIV; p++) begin
      @(negedge clk);
      sample(8'b111_01_111, p, "R9", ok);
      if (p == 2) drive(8'b010_11_000);
    end
    finish_vec(ok);
    ok = 1'b1;
    for (int p = 0; p < DIV; p++) begin
      @(negedge clk);
      sample(8'b010_11_000, p, "R9", ok);
    end
    finish_vec(ok);

    // R7: muted rails with invert rest high under a full-width code
    drive(8'b101_11_110);
    ok = 1'b1;
    for (int p = 0; p < DIV; p++) begin
      @(negedge clk);
      sample(8'b101_11_110, p, "R7", ok);
      if (ok && (tx_pos !== 1'b1 || tx_neg !== 1'b1)) begin
        $display("FAIL R7 phase=%0d actual pos/neg=%b%b expected 11", p, tx_pos, tx_neg);
        ok = 1'b0;
      end
    end
    finish_vec(ok);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", applied, miscmp);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      miscmp++;
      $display("FAIL watchdog expired actual running expected done");
      $display("== %0d vectors applied, %0d miscompares ==", applied, miscmp);
      $finish;
    end
  end
endmodule